// File: doc/BRIEF.md
# ChaCha Round Permutation Core

This block applies the twenty-round ChaCha permutation to a 512-bit state of sixteen 32-bit words. It is the core of a subkey derivation step: the caller supplies a prepared state, pulses `start`, and later collects the scrambled state when `done` pulses. The caller handles the constants, key, nonce and any final addition of the input words. The core returns only the raw permutation.

The core does not instantiate quarter-round hardware for each word group. It keeps the sixteen words in one register bank and applies a single add-XOR-rotate step per clock. A schedule counter picks the three words that each step touches. The counter walks through four steps per quarter-round, the four column groups, the four diagonal groups, and ten double rounds. A permutation therefore occupies 320 clocks.

The controller is a three-state machine. In IDLE it waits for `start` (transition LOAD: the state is captured, go to RUN). In RUN it performs one step per clock (transition STEP: stay in RUN). On the last scheduled step it takes transition FINISH to DONE. DONE raises `done` for one clock and takes transition RETIRE back to IDLE. `start` is honoured only in IDLE.

Top module: `chacha_perm_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core enters IDLE, clears all sixteen words, and drives `done` low. After reset, `state_out` reads all zeros.
- R2: A `start` seen in IDLE captures `state_in` at that edge. Word k is bits [32k+31:32k], so word 0 is in the least significant 32 bits. Until the next edge, `state_out` equals the captured `state_in`.
- R3: The column pass processes the groups (a,b,c,d) = (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15), in that order. The first step after a load updates only word 0 and word 12.
- R4: After each column pass comes a diagonal pass on the groups (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14), in that order.
- R5: Each quarter-round is four steps, one per clock, in this order: a=a+b then d=rotl(d^a,16); c=c+d then b=rotl(b^c,12); a=a+b then d=rotl(d^a,8); c=c+d then b=rotl(b^c,7). Additions are modulo 2^32 and rotations are left rotations of 32 bits.
- R6: Exactly 10 double rounds are run. The final `state_out` equals the 20-round permutation of the loaded state, with no input words added back. The all-zero state maps to all zeros.
- R7: `done` is high for exactly one clock. It becomes visible 320 clock edges after the loading edge and is low at all earlier points of the run.
- R8: A `start` during RUN or DONE is ignored. The running permutation and its result are unaffected, and no new run begins.
- R9: After `done`, `state_out` holds the result unchanged and `done` stays low until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a permutation; accepted only when idle |
| state_in | input | 512 | State to permute, word 0 in bits [31:0] |
| state_out | output | 512 | Working and final state, word 0 in bits [31:0] |
| done | output | 1 | One-clock pulse when the permutation result is ready |

## Verification
Nearly any wrong schedule index, rotate amount or step order mixes the words differently. The error then spreads through all sixteen words and shows as a full mismatch of `state_out` when `done` pulses. The bench also samples the state one clock after loading, so a wrong first index or rotate shows within one cycle. An off-by-one in the step counter or state machine moves the `done` pulse away from edge 320 or stretches it, and the bench checks the cycle exactly. A controller that accepts `start` while busy shows a corrupted result or an extra pulse within a few cycles of the injected strobe.

// File: rtl/chacha_pkg.sv
package chacha_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 16;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int STATE_W   = WORD_W * NUM_WORDS;
    localparam int STEPS_QR  = 4;
    localparam int GROUPS    = 4;
    localparam int PASSES    = 2;
    localparam int STEPS_DR  = STEPS_QR * GROUPS * PASSES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [4:0]        rot_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } fsm_t;

    function automatic word_t rotl(input word_t x, input rot_t amt);
        logic [2*WORD_W-1:0] wide;
        wide = {x, x} << amt;
        return wide[2*WORD_W-1:WORD_W];
    endfunction

    function automatic rot_t rot_for(input logic [1:0] sub);
        unique case (sub)
            2'd0: return 5'd16;
            2'd1: return 5'd12;
            2'd2: return 5'd8;
            default: return 5'd7;
        endcase
    endfunction

endpackage

// File: rtl/chacha_sched.sv
module chacha_sched
    import chacha_pkg::*;
#(
    parameter int DOUBLE_ROUNDS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic adv,
    output idx_t idx_p,
    output idx_t idx_q,
    output idx_t idx_r,
    output rot_t rot,
    output logic last
);

    localparam int TOTAL = DOUBLE_ROUNDS * STEPS_DR;
    localparam int CW    = $clog2(TOTAL);

    logic [CW-1:0] cnt;
    logic [1:0]    sub;
    logic [1:0]    grp;
    logic          diag;

    assign sub  = cnt[1:0];
    assign grp  = cnt[3:2];
    assign diag = cnt[4];
    assign last = (cnt == CW'(TOTAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (adv)    cnt <= last ? '0 : cnt + 1'b1;
    end

    // Row r of group g: column g in the column pass, column g+r in the diagonal pass.
    function automatic idx_t word_at(input logic [1:0] row, input logic [1:0] g,
                                     input logic dg);
        logic [1:0] col;
        col = dg ? (g + row) : g;
        return {row, col};
    endfunction

    // Even steps: p=a, q=b, r=d. Odd steps: p=c, q=d, r=b.
    always_comb begin
        idx_p = word_at(sub[0] ? 2'd2 : 2'd0, grp, diag);
        idx_q = word_at(sub[0] ? 2'd3 : 2'd1, grp, diag);
        idx_r = word_at(sub[0] ? 2'd1 : 2'd3, grp, diag);
        rot   = rot_for(sub);
    end

    p_idx_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (idx_p != idx_q) && (idx_p != idx_r) && (idx_q != idx_r));

    p_rot_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (rot inside {5'd16, 5'd12, 5'd8, 5'd7}));

    p_wrap_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last && !clear) |=> (cnt == '0));

    p_diag_follows_column_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clear && cnt[4:0] == 5'd15) |=> (diag && grp == 2'd0 && sub == 2'd0));

endmodule

// File: rtl/chacha_step.sv
module chacha_step
    import chacha_pkg::*;
(
    input  word_t p_in,
    input  word_t q_in,
    input  word_t r_in,
    input  rot_t  rot,
    output word_t p_out,
    output word_t r_out
);

    word_t mixed;

    always_comb begin
        p_out = p_in + q_in;
        mixed = r_in ^ p_out;
        r_out = rotl(mixed, rot);
    end

endmodule

// File: rtl/chacha_perm_core.sv
module chacha_perm_core
    import chacha_pkg::*;
#(
    parameter int DOUBLE_ROUNDS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [STATE_W-1:0] state_in,
    output logic [STATE_W-1:0] state_out,
    output logic               done
);

    fsm_t  fsm_q, fsm_d;
    logic  load, adv, last;
    idx_t  idx_p, idx_q, idx_r;
    rot_t  rot;
    word_t st_q [NUM_WORDS];
    word_t p_new, r_new;

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= S_IDLE;
        else        fsm_q <= fsm_d;
    end

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            S_IDLE:  if (start) fsm_d = S_RUN;
            S_RUN:   if (last)  fsm_d = S_DONE;
            S_DONE:  fsm_d = S_IDLE;
            default: fsm_d = S_IDLE;
        endcase
    end

    always_comb begin
        load = 1'b0;
        adv  = 1'b0;
        done = 1'b0;
        unique case (fsm_q)
            S_IDLE:  load = start;
            S_RUN:   adv  = 1'b1;
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    chacha_sched #(
        .DOUBLE_ROUNDS(DOUBLE_ROUNDS)
    ) u_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .adv   (adv),
        .idx_p (idx_p),
        .idx_q (idx_q),
        .idx_r (idx_r),
        .rot   (rot),
        .last  (last)
    );

    chacha_step u_step (
        .p_in  (st_q[idx_p]),
        .q_in  (st_q[idx_q]),
        .r_in  (st_q[idx_r]),
        .rot   (rot),
        .p_out (p_new),
        .r_out (r_new)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_WORDS; k++) st_q[k] <= '0;
        end else if (load) begin
            for (int k = 0; k < NUM_WORDS; k++) st_q[k] <= state_in[k*WORD_W +: WORD_W];
        end else if (adv) begin
            st_q[idx_p] <= p_new;
            st_q[idx_r] <= r_new;
        end
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_pack
        assign state_out[k*WORD_W +: WORD_W] = st_q[k];
    end

    p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_run_not_abandoned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == S_RUN) |=> (fsm_q != S_IDLE));

    p_done_from_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(fsm_q == S_RUN));

    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == S_IDLE && !start) |=> $stable(state_out));

    p_done_holds_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(state_out));

endmodule

// File: tb/chacha_perm_core_bench.sv
`timescale 1ns/1ps
module chacha_perm_core_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [511:0] state_in = '0;
    logic [511:0] state_out;
    logic         done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    chacha_perm_core u_chacha_perm_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .state_in  (state_in),
        .state_out (state_out),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [127:0] qr(input logic [31:0] a, b, c, d);
        a = a + b; d = rl(d ^ a, 16);
        c = c + d; b = rl(b ^ c, 12);
        a = a + b; d = rl(d ^ a, 8);
        c = c + d; b = rl(b ^ c, 7);
        return {d, c, b, a};
    endfunction

    function automatic logic [511:0] ref_perm(input logic [511:0] s);
        logic [31:0]  w [16];
        logic [127:0] t;
        logic [511:0] o;
        int           grp [8][4];
        grp = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
                '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};
        for (int k = 0; k < 16; k++) w[k] = s[k*32 +: 32];
        for (int r = 0; r < 10; r++) begin
            for (int g = 0; g < 8; g++) begin
                t = qr(w[grp[g][0]], w[grp[g][1]], w[grp[g][2]], w[grp[g][3]]);
                w[grp[g][0]] = t[31:0];
                w[grp[g][1]] = t[63:32];
                w[grp[g][2]] = t[95:64];
                w[grp[g][3]] = t[127:96];
            end
        end
        for (int k = 0; k < 16; k++) o[k*32 +: 32] = w[k];
        return o;
    endfunction

    // Runs one permutation; inj > 0 pulses start with other data at that cycle.
    task automatic do_perm(input logic [511:0] s, input int inj, input logic [511:0] other,
                           input string name);
        logic [511:0] exp, exp1;
        logic [31:0]  a0;
        int           early;
        exp  = ref_perm(s);
        exp1 = s;
        a0   = s[31:0] + s[159:128];
        exp1[31:0]    = a0;
        exp1[415:384] = rl(s[415:384] ^ a0, 16);
        early = 0;
        @(negedge clk);
        state_in = s;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(state_out == s, {"R2 load ", name}, state_out, s);
        for (int c = 1; c <= 320; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 1) chk(state_out == exp1, {"R3 R5 first step ", name}, state_out, exp1);
            if (c < 320 && done) early++;
            if (c == inj) begin
                start    = 1'b1;
                state_in = other;
            end else begin
                start = 1'b0;
            end
        end
        chk(early == 0, {"R7 no early done ", name}, 512'(early), 512'd0);
        chk(done == 1'b1, {"R7 done at 320 ", name}, 512'(done), 512'd1);
        chk(state_out == exp, {"R4 R6 result ", name}, state_out, exp);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, {"R7 done one cycle ", name}, 512'(done), 512'd0);
        early = 0;
        for (int c = 0; c < 6; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) early++;
        end
        chk(early == 0, {"R8 R9 no further done ", name}, 512'(early), 512'd0);
        chk(state_out == exp, {"R8 R9 result held ", name}, state_out, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        state_in = {16{32'hdeadbeef}};
        start = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R1 done low in reset", 512'(done), 512'd0);
        chk(state_out == '0, "R1 state cleared", state_out, '0);
        start = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(state_out == '0 && done == 1'b0, "R1 idle after reset", state_out, '0);
    endtask

    task automatic t_patterns;
        logic [511:0] inc, lf;
        logic [31:0]  x;
        for (int k = 0; k < 16; k++) inc[k*32 +: 32] = 32'(k) * 32'h01010101 + 32'h03020100;
        x = 32'h1234abcd;
        for (int k = 0; k < 16; k++) begin
            x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]} ^ (x * 32'h9e3779b9);
            lf[k*32 +: 32] = x;
        end
        do_perm('0, 0, '0, "zero");
        do_perm(inc, 0, '0, "incrementing");
        do_perm({16{32'hffffffff}}, 0, '0, "all ones");
        do_perm(lf, 0, '0, "mixed");
    endtask

    task automatic t_busy;
        logic [511:0] s, o;
        for (int k = 0; k < 16; k++) begin
            s[k*32 +: 32] = 32'h61707865 ^ (32'(k) << 20) ^ 32'(k * 7919);
            o[k*32 +: 32] = ~s[k*32 +: 32];
        end
        do_perm(s, 100, o, "R8 start mid run");
        do_perm(o, 320, s, "R8 start during done");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_patterns();
        t_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule